// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel I/O

This block holds a word of parameterised width (eight bits by default). On each rising clock edge it can keep its contents, move them one place toward the high end, move them one place toward the low end, or capture a new word from the parallel data lines. A two-bit mode input selects the operation. An active-low master reset clears the whole word at once. The reset takes hold without waiting for a clock, but its release is aligned to the clock.

The parallel data lines are bidirectional at chip level. Here each line is split into an input bus, an output bus and a per-bit drive enable. The block drives the lines only when both active-low enables are low and the mode is not parallel load, so external logic can put a new word on the same lines for capture. The lowest and highest stages also appear on dedicated outputs that are never gated. Serial inputs feed both end stages. Chaining the end outputs of one register into the serial inputs of the next builds longer words.

Top module: `usr_shift_reg`

## Requirements
- R1: While `rst_n` is low, every stage reads zero, without waiting for a clock edge and whatever `mode_sel` and the clock do.
- R2: After `rst_n` returns high, the register ignores `mode_sel` on the first two rising edges and obeys it from the third.
- R3: With `mode_sel` = 2'b00, a rising edge leaves every stage unchanged.
- R4: With `mode_sel` = 2'b01, a rising edge moves stage n-1 into stage n and loads `ser_right_in` into stage 0.
- R5: With `mode_sel` = 2'b10, a rising edge moves stage n+1 into stage n and loads `ser_left_in` into the top stage.
- R6: With `mode_sel` = 2'b11, a rising edge copies `pio_in[i]` into stage i.
- R7: `pio_oe` is all ones when `oe_a_n` and `oe_b_n` are both low and `mode_sel` is not 2'b11, and all zeros otherwise. `pio_out` always shows the stored word.
- R8: Holding either output enable high changes no shift, load or hold result.
- R9: `end_lo` always equals stage 0 and `end_hi` always equals the top stage, whatever the output-enable state.
- R10: Two instances joined through `end_hi` to `ser_right_in` and `end_lo` to `ser_left_in` act as one register of twice the width in both shift directions.
- R11: In every mode other than 2'b11, `pio_in` has no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low master reset; clears at once, release is synchronised |
| mode_sel | input | 2 | 00 hold, 01 shift toward high end, 10 shift toward low end, 11 parallel load |
| oe_a_n | input | 1 | Active-low output enable, first of two |
| oe_b_n | input | 1 | Active-low output enable, second of two |
| ser_right_in | input | 1 | Serial bit entering stage 0 on a shift toward the high end |
| ser_left_in | input | 1 | Serial bit entering the top stage on a shift toward the low end |
| pio_in | input | W | Input side of the shared parallel lines |
| pio_out | output | W | Output side of the shared parallel lines; always the stored word |
| pio_oe | output | W | Per-bit drive enable for the shared lines |
| end_lo | output | 1 | Stage 0, ungated, for cascading |
| end_hi | output | 1 | Top stage, ungated, for cascading |

## Verification
Master reset and a parallel load can arrive in the same cycle. The bench holds mode 2'b11 with a fresh word on `pio_in` while it pulls `rst_n` low between edges. It expects zero before the next edge and through the edges that follow. It then releases reset with the load still selected and expects the word to appear only after the third edge. A mid-run reset during a right shift is handled the same way. Output disable and parallel load also overlap. The bench loads with one enable high and expects `pio_oe` to be zero while the captured word still matches the load data.

// File: rtl/usr_pkg.sv
// Package: shared mode encoding for the universal shift register.
// Assumes the two-bit select is ordered {high select, low select}.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_rst_sync.sv
// Reset release synchroniser: asserts at once, releases after STAGES edges.
// Assumes STAGES >= 2.
module usr_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the chain immediately on assertion.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/usr_stage.sv
// One register slice: a four-way next-state mux and a flip-flop.
// Assumes the neighbours are wired by the parent; reset is asynchronous.
module usr_stage
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  usr_mode_e mode,
    input  logic      from_lower,
    input  logic      from_upper,
    input  logic      par_in,
    output logic      q
);
    logic next_d;

    // Select the value this slice takes on the next rising edge.
    always_comb begin
        unique case (mode)
            MODE_HOLD: next_d = q;
            MODE_SHR:  next_d = from_lower;
            MODE_SHL:  next_d = from_upper;
            default:   next_d = par_in;
        endcase
    end

    // Storage flop, cleared whenever the reset is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= next_d;
    end
endmodule

// File: rtl/usr_out_ctrl.sv
// Drive-enable decode for the shared parallel lines.
// Assumes both enables are active low; load mode always releases the lines.
module usr_out_ctrl
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  usr_mode_e      mode,
    input  logic           oe_a_n,
    input  logic           oe_b_n,
    output logic [W-1:0]   pio_oe
);
    logic drive_en;

    // Drive only with both enables low and no external load pending.
    always_comb begin
        drive_en = !oe_a_n && !oe_b_n && (mode != MODE_LOAD);
        pio_oe   = {W{drive_en}};
    end
endmodule

// File: rtl/usr_shift_reg.sv
// Top: W-stage universal shift register with shared parallel I/O.
// Assumes W >= 2. The reset clears at once and is released on the clock.
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int W          = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_sel,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic         ser_right_in,
    input  logic         ser_left_in,
    input  logic [W-1:0] pio_in,
    output logic [W-1:0] pio_out,
    output logic [W-1:0] pio_oe,
    output logic         end_lo,
    output logic         end_hi
);
    localparam int TOP = W - 1;

    usr_mode_e    mode;
    logic         rst_sync_n;
    logic [W-1:0] q;

    assign mode = usr_mode_e'(mode_sel);

    usr_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (rst_sync_n)
    );

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic lower_src;
        logic upper_src;
        if (i == 0) begin : g_lo_end
            assign lower_src = ser_right_in;
        end else begin : g_lo_mid
            assign lower_src = q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign upper_src = ser_left_in;
        end else begin : g_hi_mid
            assign upper_src = q[i+1];
        end
        usr_stage u_stage (
            .clk        (clk),
            .rst_n      (rst_sync_n),
            .mode       (mode),
            .from_lower (lower_src),
            .from_upper (upper_src),
            .par_in     (pio_in[i]),
            .q          (q[i])
        );
    end

    usr_out_ctrl #(.W(W)) u_out_ctrl (
        .mode   (mode),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .pio_oe (pio_oe)
    );

    assign pio_out = q;
    assign end_lo  = q[0];
    assign end_hi  = q[TOP];

    // R1: any edge seen while the internal reset is low finds the word clear.
    p_clear_in_reset_r1: assert property (@(posedge clk)
        !rst_sync_n |-> (q == '0));

    // R3: hold keeps the word.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (mode_sel == 2'b00) |=> (q == $past(q)));

    // R4: right shift moves each stage up and admits the right serial bit.
    p_shr_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (mode_sel == 2'b01) |=> (q == {$past(q[TOP-1:0]), $past(ser_right_in)}));

    // R5: left shift moves each stage down and admits the left serial bit.
    p_shl_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (mode_sel == 2'b10) |=> (q == {$past(ser_left_in), $past(q[TOP:1])}));

    // R6: parallel load captures the shared lines.
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (mode_sel == 2'b11) |=> (q == $past(pio_in)));

    // R7: lines are released in load mode or with either enable high.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == 2'b11) || oe_a_n || oe_b_n) |-> (pio_oe == '0));
endmodule

// File: tb/usr_shift_reg_tb.sv
// Scoreboard bench: two chained instances modelled as one 16-bit register.
module usr_shift_reg_tb;
    localparam int W = 8;

    typedef struct {
        logic [2*W-1:0] exp_word;
        logic [W-1:0]   exp_oe;
        string          tag;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode_sel = 2'b00;
    logic           oe_a_n = 1'b0;
    logic           oe_b_n = 1'b0;
    logic           sr_in = 1'b0;
    logic           sl_in = 1'b0;
    logic [W-1:0]   pin_lo = '0;
    logic [W-1:0]   pin_hi = '0;
    logic [W-1:0]   pout_lo, pout_hi, poe_lo, poe_hi;
    logic           lo_end_lo, lo_end_hi, hi_end_lo, hi_end_hi;

    int             checks = 0;
    int             failures = 0;
    int             cycles = 0;
    logic [2*W-1:0] model = '0;
    item_t          sb[$];

    always #2 clk = ~clk;

    usr_shift_reg #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_right_in(sr_in), .ser_left_in(hi_end_lo),
        .pio_in(pin_lo), .pio_out(pout_lo), .pio_oe(poe_lo),
        .end_lo(lo_end_lo), .end_hi(lo_end_hi)
    );

    usr_shift_reg #(.W(W)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_right_in(lo_end_hi), .ser_left_in(sl_in),
        .pio_in(pin_hi), .pio_out(pout_hi), .pio_oe(poe_hi),
        .end_lo(hi_end_lo), .end_hi(hi_end_hi)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one operation at a falling edge and queue its result.
    task automatic op(input logic [1:0] m, input logic a_n, input logic b_n,
                      input logic sr, input logic sl,
                      input logic [W-1:0] lo, input logic [W-1:0] hi,
                      input string tag);
        item_t it;
        @(negedge clk);
        mode_sel = m; oe_a_n = a_n; oe_b_n = b_n;
        sr_in = sr; sl_in = sl; pin_lo = lo; pin_hi = hi;
        case (m)
            2'b01:   model = {model[2*W-2:0], sr};
            2'b10:   model = {sl, model[2*W-1:1]};
            2'b11:   model = {hi, lo};
            default: model = model;
        endcase
        it.exp_word = model;
        it.exp_oe   = (!a_n && !b_n && m != 2'b11) ? '1 : '0;
        it.tag      = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare the outputs just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk({pout_hi, pout_lo} == it.exp_word, it.tag,
                32'({pout_hi, pout_lo}), 32'(it.exp_word));
            chk(poe_lo == it.exp_oe && poe_hi == it.exp_oe, "R7 pio_oe",
                32'({poe_hi, poe_lo}), 32'({it.exp_oe, it.exp_oe}));
            chk(lo_end_lo == it.exp_word[0] && lo_end_hi == it.exp_word[W-1] &&
                hi_end_lo == it.exp_word[W] && hi_end_hi == it.exp_word[2*W-1],
                "R9 end outputs",
                32'({hi_end_hi, hi_end_lo, lo_end_hi, lo_end_lo}),
                32'({it.exp_word[2*W-1], it.exp_word[W], it.exp_word[W-1], it.exp_word[0]}));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state with load selected and clock running.
        mode_sel = 2'b11; pin_lo = 8'hAA; pin_hi = 8'h55;
        repeat (2) @(posedge clk);
        #1;
        chk({pout_hi, pout_lo} == 16'h0, "R1 reset state", 32'({pout_hi, pout_lo}), 0);

        // R2: release during load; first two edges ignored.
        @(negedge clk);
        rst_n = 1'b1; pin_lo = 8'h5A; pin_hi = 8'hC3;
        @(posedge clk); #1;
        chk({pout_hi, pout_lo} == 16'h0, "R2 edge1", 32'({pout_hi, pout_lo}), 0);
        @(posedge clk); #1;
        chk({pout_hi, pout_lo} == 16'h0, "R2 edge2", 32'({pout_hi, pout_lo}), 0);
        @(posedge clk); #1;
        chk({pout_hi, pout_lo} == 16'hC35A, "R2 edge3 load", 32'({pout_hi, pout_lo}), 32'hC35A);
        model = 16'hC35A;

        // R3/R11: hold with changing pio_in.
        op(2'b00, 0, 0, 1, 1, 8'hFF, 8'h00, "R3 R11 hold");
        op(2'b00, 0, 0, 0, 0, 8'h0F, 8'hF0, "R3 R11 hold");

        // R4/R10/R11: cascaded right shifts with noise on pio_in.
        for (int i = 0; i < 2*W; i++)
            op(2'b01, 0, 0, 1'((i * 5 + 1) % 3 == 0), 0, 8'(i * 37), 8'(i * 91),
               "R4 R10 R11 shift right");

        // R5/R10: cascaded left shifts.
        for (int i = 0; i < 2*W; i++)
            op(2'b10, 0, 0, 0, 1'(i % 3 != 1), 8'(i * 13), 8'(i * 29),
               "R5 R10 shift left");

        // R6/R8/R7: load with one enable high, then with none.
        op(2'b11, 1, 0, 0, 0, 8'h3C, 8'h81, "R6 R8 load oe_a high");
        op(2'b11, 0, 0, 0, 0, 8'h96, 8'h69, "R6 load");
        op(2'b01, 0, 1, 1, 0, 8'h00, 8'hFF, "R8 R4 shift oe_b high");
        op(2'b10, 1, 1, 0, 1, 8'h00, 8'hFF, "R8 R5 shift both high");
        op(2'b00, 1, 0, 0, 0, 8'h12, 8'h34, "R8 R3 hold oe_a high");

        // R1: reset in the middle of a right shift.
        @(negedge clk);
        mode_sel = 2'b01; sr_in = 1'b1;
        #1 rst_n = 1'b0;
        #0.5;
        chk({pout_hi, pout_lo} == 16'h0, "R1 async clear", 32'({pout_hi, pout_lo}), 0);
        @(posedge clk); #1;
        chk({pout_hi, pout_lo} == 16'h0, "R1 held through edge", 32'({pout_hi, pout_lo}), 0);
        @(negedge clk);
        mode_sel = 2'b00; rst_n = 1'b1;
        repeat (3) @(posedge clk);
        model = '0;

        // R6/R4/R5 after recovery.
        op(2'b11, 0, 0, 0, 0, 8'h01, 8'h80, "R6 load after reset");
        op(2'b10, 0, 0, 0, 1, 8'hEE, 8'hEE, "R5 R10 shift left");
        op(2'b01, 0, 0, 0, 0, 8'hEE, 8'hEE, "R4 R10 shift right");
        op(2'b00, 0, 0, 0, 0, 8'hEE, 8'hEE, "R3 hold");

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule